// File: doc/BRIEF.md
# Receive Timestamp Capture Slots

This block holds hardware receive timestamps until software collects them. When the receive path flags a packet that needs a timestamp, the block copies the 64-bit nanosecond time input into a free slot. In the same cycle it returns that slot's index, so the index can travel with the packet's receive indication. A slot that holds a value stays locked, and no later capture can overwrite it. The lock ends only when software reads the upper 32-bit half of that slot.

Software sees a small register space on a simple read port. One register holds the occupancy bitmap. A second register reports capture events and overflow, and reading it clears them. Each slot has a lower and an upper 32-bit readout register. If every slot is occupied, the block drops the capture request. It then sets a sticky overflow flag and advances a saturating drop counter. A slot that software never reads stays locked for good, so software must read its upper half to free it.

Top module: `ts_rx_latch_bank`

## Requirements
- R1: After synchronous reset, every slot is free (`slot_latched` = 0), `overflow` is 0, `drop_count` is 0 and `cap_valid` is 0.
- R2: When `cap_req` is high, `cap_valid` rises in the same cycle and `cap_slot` gives the lowest-numbered slot that is not latched.
- R3: A granted capture stores the `cur_time` of its request cycle into the chosen slot and sets that slot's `slot_latched` bit after the clock edge. Register address 0 reads the occupancy bitmap, with bit i standing for slot i.
- R4: A latched slot keeps its stored value through any later capture requests, including requests that are dropped.
- R5: For slot i, address 4+2i returns time bits 31:0 and address 5+2i returns bits 63:32. `rd_data` is valid in the cycle after `rd_en`. Reading the lower half leaves the latch unchanged.
- R6: Reading a slot's upper half clears its latched bit after that edge, and the slot can then take a new capture.
- R7: If a capture arrives in the same cycle as a release read of a latched slot, the release takes effect. The capture goes to the lowest free slot other than the released one. If no such slot exists, the capture is dropped.
- R8: With all slots latched, a capture request leaves `cap_valid` low. It sets the sticky `overflow` flag and raises `drop_count` by one. `drop_count` saturates at its all-ones value.
- R9: Address 1 reads the event register. Bit i is set by a capture into slot i, and bit 16 mirrors `overflow`. Reading it returns the value and clears it. An event that arrives in the same cycle as the clearing read is kept.
- R10: Addresses 2, 3 and those beyond the last slot read as 0. Reads of these addresses, or of address 0, leave the latched bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 64 | Current time in nanoseconds |
| cap_req | input | 1 | Capture request for an arriving packet |
| cap_valid | output | 1 | Capture granted this cycle |
| cap_slot | output | $clog2(NUM_SLOTS) | Slot index granted to the packet |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register word address |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| slot_latched | output | NUM_SLOTS | Occupancy bitmap |
| overflow | output | 1 | Sticky dropped-capture flag |
| drop_count | output | DROP_W | Saturating count of dropped captures |

## Verification
The bench builds the block with four slots and a 3-bit drop counter. With that narrow counter, saturation at 7 can be reached in a handful of dropped requests instead of tens of thousands. Four slots keep the full-bank case only four captures away. This makes it possible to test release-versus-capture collisions both with another free slot and with none.

// File: rtl/ts_latch_pkg.sv
`timescale 1ns/1ps
package ts_latch_pkg;
    localparam int TIME_W         = 64;
    localparam int REG_W          = 32;
    localparam int ADDR_W         = 4;
    localparam int MAX_SLOTS      = 6;
    localparam int EVT_OVF_BIT    = 16;
    localparam logic [ADDR_W-1:0] ADDR_OCCUPY    = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_EVENT     = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_SLOT_BASE = 4'd4;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_OCCUPY,
        ACC_EVENT,
        ACC_SLOT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [2:0] slot;
        logic       upper;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nslots);
        reg_dec_t d;
        logic [ADDR_W-1:0] off;
        d   = '{kind: ACC_NONE, slot: 3'd0, upper: 1'b0};
        off = a - ADDR_SLOT_BASE;
        if (a == ADDR_OCCUPY) begin
            d.kind = ACC_OCCUPY;
        end else if (a == ADDR_EVENT) begin
            d.kind = ACC_EVENT;
        end else if (a >= ADDR_SLOT_BASE) begin
            if (32'(off[ADDR_W-1:1]) < nslots) begin
                d.kind  = ACC_SLOT;
                d.slot  = off[ADDR_W-1:1];
                d.upper = off[0];
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/ts_slot_pick.sv
`timescale 1ns/1ps
module ts_slot_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             req,
    input  logic [N-1:0]     occupied,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req && !occupied[i]) begin
                valid    = 1'b1;
                idx      = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ts_slot_store.sv
`timescale 1ns/1ps
module ts_slot_store
    import ts_latch_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [TIME_W-1:0]         cur_time,
    input  logic [N-1:0]              grant,
    input  logic [N-1:0]              release_i,
    output logic [N-1:0]              latched,
    output logic [N-1:0][TIME_W-1:0]  slot_time
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                latched[g]   <= 1'b0;
                slot_time[g] <= '0;
            end else begin
                latched[g] <= (latched[g] & ~release_i[g]) | grant[g];
                if (grant[g]) begin
                    slot_time[g] <= cur_time;
                end
            end
        end

        assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
            latched[g] && !release_i[g] |=> $stable(slot_time[g]) && latched[g]);

        assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
            grant[g] |=> latched[g] && (slot_time[g] == $past(cur_time)));

        assert_release_R6: assert property (@(posedge clk) disable iff (rst)
            release_i[g] && !grant[g] |=> !latched[g]);
    end
endmodule

// File: rtl/ts_event_track.sv
`timescale 1ns/1ps
module ts_event_track #(
    parameter int N      = 4,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      grant,
    input  logic              drop,
    input  logic              clear,
    output logic [N-1:0]      events,
    output logic              overflow,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            events     <= '0;
            overflow   <= 1'b0;
            drop_count <= '0;
        end else begin
            events   <= (clear ? '0 : events) | grant;
            overflow <= (clear ? 1'b0 : overflow) | drop;
            if (drop && (drop_count != CNT_MAX)) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        drop |=> overflow);

    assert_drop_count_R8: assert property (@(posedge clk) disable iff (rst)
        drop && (drop_count != CNT_MAX) |=> drop_count == $past(drop_count) + 1'b1);

    assert_event_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (|(events & $past(grant))));
endmodule

// File: rtl/ts_reg_read.sv
`timescale 1ns/1ps
module ts_reg_read
    import ts_latch_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [N-1:0]             latched,
    input  logic [N-1:0]             events,
    input  logic                     overflow,
    input  logic [N-1:0][TIME_W-1:0] slot_time,
    output logic [REG_W-1:0]         rd_data,
    output logic [N-1:0]             release_o,
    output logic                     evt_clear
);
    reg_dec_t          dec;
    logic [TIME_W-1:0] sel_time;
    logic [REG_W-1:0]  nxt_data;

    always_comb begin
        dec      = decode_addr(rd_addr, N);
        sel_time = '0;
        for (int i = 0; i < N; i++) begin
            if (dec.slot == 3'(i)) begin
                sel_time = slot_time[i];
            end
        end
        nxt_data = '0;
        case (dec.kind)
            ACC_OCCUPY: nxt_data[N-1:0] = latched;
            ACC_EVENT: begin
                nxt_data[N-1:0]         = events;
                nxt_data[EVT_OVF_BIT]   = overflow;
            end
            ACC_SLOT:   nxt_data = dec.upper ? sel_time[TIME_W-1:REG_W]
                                             : sel_time[REG_W-1:0];
            default:    nxt_data = '0;
        endcase
    end

    for (genvar g = 0; g < N; g++) begin : g_rel
        assign release_o[g] = rd_en && (dec.kind == ACC_SLOT) && dec.upper
                              && (dec.slot == 3'(g));
    end

    assign evt_clear = rd_en && (dec.kind == ACC_EVENT);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= nxt_data;
        end
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en && (dec.kind == ACC_NONE) |=> rd_data == '0);
endmodule

// File: rtl/ts_rx_latch_bank.sv
`timescale 1ns/1ps
module ts_rx_latch_bank
    import ts_latch_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DROP_W    = 16,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cur_time,
    input  logic              cap_req,
    output logic              cap_valid,
    output logic [IDX_W-1:0]  cap_slot,
    input  logic              rd_en,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [NUM_SLOTS-1:0] slot_latched,
    output logic              overflow,
    output logic [DROP_W-1:0] drop_count
);
    logic [NUM_SLOTS-1:0]             grant;
    logic [NUM_SLOTS-1:0]             rel;
    logic [NUM_SLOTS-1:0]             events;
    logic [NUM_SLOTS-1:0][TIME_W-1:0] slot_time;
    logic                             evt_clear;
    logic                             cap_drop;
    reg_dec_t                         top_dec;

    initial begin
        assert (NUM_SLOTS >= 1 && NUM_SLOTS <= MAX_SLOTS)
            else $error("NUM_SLOTS out of range for the register map");
    end

    ts_slot_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) pick_i (
        .req      (cap_req),
        .occupied (slot_latched),
        .valid    (cap_valid),
        .idx      (cap_slot),
        .grant    (grant)
    );

    assign cap_drop = cap_req && !cap_valid;

    ts_slot_store #(.N(NUM_SLOTS)) store_i (
        .clk       (clk),
        .rst       (rst),
        .cur_time  (cur_time),
        .grant     (grant),
        .release_i (rel),
        .latched   (slot_latched),
        .slot_time (slot_time)
    );

    ts_event_track #(.N(NUM_SLOTS), .DROP_W(DROP_W)) evt_i (
        .clk        (clk),
        .rst        (rst),
        .grant      (grant),
        .drop       (cap_drop),
        .clear      (evt_clear),
        .events     (events),
        .overflow   (overflow),
        .drop_count (drop_count)
    );

    ts_reg_read #(.N(NUM_SLOTS)) rd_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .latched   (slot_latched),
        .events    (events),
        .overflow  (overflow),
        .slot_time (slot_time),
        .rd_data   (rd_data),
        .release_o (rel),
        .evt_clear (evt_clear)
    );

    assign top_dec = decode_addr(rd_addr, NUM_SLOTS);

    assert_pick_free_R2: assert property (@(posedge clk) disable iff (rst)
        cap_req && cap_valid |-> !slot_latched[cap_slot]);

    assert_drop_full_R8: assert property (@(posedge clk) disable iff (rst)
        cap_req && !cap_valid |-> (&slot_latched));

    assert_release_wins_R7: assert property (@(posedge clk) disable iff (rst)
        cap_valid && (|(rel & slot_latched)) |=> (|($past(rel) & ~slot_latched)));

    assert_no_side_effect_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en && (top_dec.kind != ACC_SLOT) && !cap_valid |=> $stable(slot_latched));
endmodule

// File: tb/ts_rx_latch_bank_tb_top.sv
`timescale 1ns/1ps
module ts_rx_latch_bank_tb_top;
    localparam int NS     = 4;
    localparam int DW     = 3;
    localparam int NV     = 20;

    typedef struct packed {
        logic        cap;
        logic        rd;
        logic [3:0]  addr;
        logic [63:0] tm;
        logic        exp_v;
        logic [1:0]  exp_slot;
        logic [3:0]  exp_lat;
        logic [31:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R2 R3: first captures fill slots 0 and 1
        '{1'b1, 1'b0, 4'd0,  64'hA000_0001_0000_0010, 1'b1, 2'd0, 4'b0001, 32'h0, 4'd2},
        '{1'b1, 1'b0, 4'd0,  64'hA000_0002_0000_0020, 1'b1, 2'd1, 4'b0011, 32'h0, 4'd2},
        // R5: lower read keeps latch; R6: upper read frees slot 0
        '{1'b0, 1'b1, 4'd4,  64'h0, 1'b0, 2'd0, 4'b0011, 32'h0000_0010, 4'd5},
        '{1'b0, 1'b1, 4'd5,  64'h0, 1'b0, 2'd0, 4'b0010, 32'hA000_0001, 4'd6},
        // R6: freed slot reused, then fill
        '{1'b1, 1'b0, 4'd0,  64'hB000_0003_0000_0030, 1'b1, 2'd0, 4'b0011, 32'h0, 4'd6},
        '{1'b1, 1'b0, 4'd0,  64'hC000_0004_0000_0040, 1'b1, 2'd2, 4'b0111, 32'h0, 4'd2},
        '{1'b1, 1'b0, 4'd0,  64'hD000_0005_0000_0050, 1'b1, 2'd3, 4'b1111, 32'h0, 4'd2},
        // R8: full bank drops
        '{1'b1, 1'b0, 4'd0,  64'hE000_0006_0000_0060, 1'b0, 2'd0, 4'b1111, 32'h0, 4'd8},
        // R3: occupancy register
        '{1'b0, 1'b1, 4'd0,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0000_000F, 4'd3},
        // R9: event register read clears
        '{1'b0, 1'b1, 4'd1,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0001_000F, 4'd9},
        '{1'b0, 1'b1, 4'd1,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0000_0000, 4'd9},
        // R7: release of slot 1 with no other free slot -> drop
        '{1'b1, 1'b1, 4'd7,  64'hF000_0007_0000_0070, 1'b0, 2'd0, 4'b1101, 32'hA000_0002, 4'd7},
        // R7: release of slot 2, capture goes to slot 1
        '{1'b1, 1'b1, 4'd9,  64'h1234_5678_9ABC_DEF0, 1'b1, 2'd1, 4'b1011, 32'hC000_0004, 4'd7},
        '{1'b1, 1'b0, 4'd0,  64'h0BAD_0008_0000_0080, 1'b1, 2'd2, 4'b1111, 32'h0, 4'd6},
        '{1'b0, 1'b1, 4'd6,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h9ABC_DEF0, 4'd7},
        '{1'b0, 1'b1, 4'd1,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0001_0006, 4'd9},
        // R10: unmapped address
        '{1'b0, 1'b1, 4'd3,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0000_0000, 4'd10},
        '{1'b0, 1'b1, 4'd8,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0000_0080, 4'd5},
        // R4: slot 0 kept its value through drops
        '{1'b0, 1'b1, 4'd4,  64'h0, 1'b0, 2'd0, 4'b1111, 32'h0000_0030, 4'd4},
        '{1'b0, 1'b1, 4'd11, 64'h0, 1'b0, 2'd0, 4'b0111, 32'hD000_0005, 4'd6}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [63:0]   cur_time;
    logic          cap_req;
    logic          cap_valid;
    logic [1:0]    cap_slot;
    logic          rd_en;
    logic [3:0]    rd_addr;
    logic [31:0]   rd_data;
    logic [NS-1:0] slot_latched;
    logic          overflow;
    logic [DW-1:0] drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ts_rx_latch_bank #(.NUM_SLOTS(NS), .DROP_W(DW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cur_time     (cur_time),
        .cap_req      (cap_req),
        .cap_valid    (cap_valid),
        .cap_slot     (cap_slot),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .slot_latched (slot_latched),
        .overflow     (overflow),
        .drop_count   (drop_count)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic [3:0] a,
                         input logic [63:0] t);
        cap_req  = c;
        rd_en    = r;
        rd_addr  = a;
        cur_time = t;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 4'd0, 64'h0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "latched", 64'(slot_latched), 64'h0);
        chk("R1", "overflow", 64'(overflow), 64'h0);
        chk("R1", "drop_count", 64'(drop_count), 64'h0);
        chk("R1", "cap_valid", 64'(cap_valid), 64'h0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            drive(VECS[k].cap, VECS[k].rd, VECS[k].addr, VECS[k].tm);
            #1;
            chk(tag, $sformatf("vec%0d cap_valid", k), 64'(cap_valid), 64'(VECS[k].exp_v));
            if (VECS[k].exp_v)
                chk(tag, $sformatf("vec%0d cap_slot", k), 64'(cap_slot), 64'(VECS[k].exp_slot));
            @(negedge clk);
            drive(1'b0, 1'b0, 4'd0, 64'h0);
            chk(tag, $sformatf("vec%0d latched", k), 64'(slot_latched), 64'(VECS[k].exp_lat));
            if (VECS[k].rd)
                chk(tag, $sformatf("vec%0d rd_data", k), 64'(rd_data), 64'(VECS[k].exp_rd));
        end

        // R8: saturation of the drop counter (2 drops so far)
        drive(1'b1, 1'b0, 4'd0, 64'h0000_0009_0000_0090);
        #1 chk("R2", "slot3 cap_slot", 64'(cap_slot), 64'd3);
        @(negedge clk);
        for (int d = 0; d < 6; d++) begin
            drive(1'b1, 1'b0, 4'd0, 64'h5555_0000_0000_0000);
            #1 chk("R8", "full cap_valid", 64'(cap_valid), 64'h0);
            @(negedge clk);
        end
        drive(1'b0, 1'b0, 4'd0, 64'h0);
        chk("R8", "drop_count saturated", 64'(drop_count), 64'd7);
        chk("R8", "overflow sticky", 64'(overflow), 64'h1);
        chk("R4", "latched after drops", 64'(slot_latched), 64'hF);

        // R9: event set in same cycle as clearing read survives
        drive(1'b0, 1'b1, 4'd5, 64'h0);
        @(negedge clk);
        chk("R6", "slot0 freed", 64'(slot_latched), 64'hE);
        drive(1'b1, 1'b1, 4'd1, 64'h7777_0000_0000_0001);
        #1 chk("R2", "slot0 regrant", 64'(cap_slot), 64'd0);
        @(negedge clk);
        chk("R9", "event read value", 64'(rd_data), 64'h0001_0008);
        chk("R9", "overflow cleared", 64'(overflow), 64'h0);
        drive(1'b0, 1'b1, 4'd1, 64'h0);
        @(negedge clk);
        chk("R9", "event kept", 64'(rd_data), 64'h0000_0001);
        drive(1'b0, 1'b1, 4'd4, 64'h0);
        @(negedge clk);
        chk("R3", "captured low word", 64'(rd_data), 64'h0000_0001);

        // R1: reset in mid-run
        drive(1'b0, 1'b0, 4'd0, 64'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "latched after reset", 64'(slot_latched), 64'h0);
        chk("R1", "drop after reset", 64'(drop_count), 64'h0);
        drive(1'b1, 1'b0, 4'd0, 64'h1);
        #1 chk("R2", "slot0 after reset", 64'(cap_slot), 64'd0);
        @(negedge clk);
        drive(1'b0, 1'b0, 4'd0, 64'h0);
        chk("R3", "latched after capture", 64'(slot_latched), 64'h1);

        finish_run();
    end
endmodule